// File: doc/BRIEF.md
# DAC Noise and Triangle Waveform Shaper

This block sits between the data written for a 12-bit DAC channel and that channel's output register. It adds a waveform offset to a base data word. A 2-bit mode code selects the offset: none, a pseudo-random value taken from a 12-bit linear feedback shift register, or a value from an up/down triangle counter. Each waveform source moves one step only when a trigger strobe is present in a clock cycle. A 4-bit amplitude code sets how many low bits of the noise register are kept, or how high the triangle counter climbs.

A small state machine controls the block. It has four states. `ST_PASS` means no waveform. `ST_NOISE` means the noise source is active. `ST_RISE` and `ST_FALL` mean the triangle counter is climbing or descending. The transitions are:
- Entry: a change of the mode code sends the machine to `ST_PASS`, `ST_NOISE` or `ST_RISE`, according to the new code, and restarts both sources.
- Turn-down: `ST_RISE` moves to `ST_FALL` on a trigger when the count is at or above the peak.
- Turn-up: `ST_FALL` moves to `ST_RISE` on a trigger when the count is zero.
- Hold: in every other case the state stays the same.

The result is the base word plus the selected offset, modulo 4096. It is combinational from the registered waveform state and the live `base_i` and `amp_i` inputs. The caller loads it into the DAC output register.

Top module: `dac_wave_shaper`

## Requirements
- R1: With mode code 00, `result_o` equals `base_i` whatever `trig_i` and `amp_i` do.
- R2: With mode code 01, `result_o` = (`base_i` + (noise register AND span mask)) mod 4096. After a mode change, the noise register holds 0xAAA.
- R3: In mode 01, each cycle with `trig_i` high advances the noise register once. The feedback bit fb is the XOR of bits 0, 1, 4 and 6. The next state is {fb, s[11:1]}, and a zero next state is replaced by 0xAAA. Cycles without a trigger leave the register unchanged.
- R4: The span mask for amplitude code N keeps bits 0..min(N,11): it has min(N+1,12) low ones. Codes 11 to 15 keep all 12 bits.
- R5: With mode code 10 or 11, the triangle count starts at 0. It rises by 1 per trigger until it reaches the peak, which equals the span mask value (2^min(N+1,12)−1). It then falls by 1 per trigger to 0 and rises again. `result_o` = (`base_i` + count) mod 4096.
- R6: If the amplitude code is lowered while the count is rising and the count is at or above the new peak, the next trigger starts the descent (count − 1).
- R7: Any change of the 2-bit mode code, including 10 to 11, restarts the noise register at 0xAAA and the triangle count at 0, rising. A trigger in the same cycle as the change is ignored.
- R8: The addition wraps modulo 4096, with no saturation.
- R9: During and just after reset, the block is in pass-through and `result_o` equals `base_i`.
- R10: The waveform state changes only at a clock edge that samples `trig_i` high. `result_o` follows `base_i` and `amp_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Mode code: 00 none, 01 noise, 1x triangle |
| amp_i | input | 4 | Amplitude code N (span of min(N+1,12) bits) |
| base_i | input | 12 | Base data word |
| trig_i | input | 1 | Trigger strobe, one step per high cycle |
| result_o | output | 12 | Base plus waveform, mod 4096 |

## Verification
The bench sweeps every amplitude code in noise and triangle modes against an arithmetic model. In triangle mode it runs each setting over a full period, so it checks both turn points and the peak values for spans of 1 to 12 bits. A counter that turned one step late or early would show a count of peak+1 or a repeated value. A mask that was off by one bit, or that did not saturate above code 11, would show miscompares in the noise sums. The bench also checks a mode change that arrives together with a trigger, and a change from 10 to 11: a design that let the trigger through or skipped the restart would give a result other than the base plus 0 or plus 0xAAA masked. A lowered amplitude during the climb is checked too: a design that compared only for equality with the peak would keep climbing past it. Finally, the bench uses bases near 0xFFF, where a saturating adder would clip instead of wrapping.

// File: rtl/dws_pkg.sv
`timescale 1ns/1ps
package dws_pkg;

    // Waveform controller states
    typedef enum logic [1:0] {
        ST_PASS  = 2'd0,
        ST_NOISE = 2'd1,
        ST_RISE  = 2'd2,
        ST_FALL  = 2'd3
    } wave_state_e;

    // Mode code decode: 00 none, 01 noise, 1x triangle
    function automatic wave_state_e entry_state(input logic [1:0] code);
        wave_state_e s;
        if (code[1])        s = ST_RISE;
        else if (code[0])   s = ST_NOISE;
        else                s = ST_PASS;
        return s;
    endfunction

endpackage

// File: rtl/dws_span_mask.sv
`timescale 1ns/1ps
module dws_span_mask #(
    parameter int DATA_W = 12,
    parameter int AMP_W  = 4
) (
    input  logic [AMP_W-1:0]  amp_i,
    output logic [DATA_W-1:0] mask_o
);

    // Bit g is kept when g <= amp; saturates naturally at DATA_W bits
    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        assign mask_o[g] = (32'(amp_i) >= 32'(g));
    end

endmodule

// File: rtl/dws_lfsr.sv
`timescale 1ns/1ps
module dws_lfsr #(
    parameter int              DATA_W = 12,
    parameter logic [DATA_W-1:0] SEED = 12'hAAA,
    parameter logic [DATA_W-1:0] TAPS = 12'h053
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              step_i,
    output logic [DATA_W-1:0] state_o
);

    logic [DATA_W-1:0] state_q;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] next_val;
    logic              fb;

    always_comb begin
        fb       = ^(state_q & TAPS);
        shifted  = {fb, state_q[DATA_W-1:1]};
        next_val = (shifted == '0) ? SEED : shifted;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         state_q <= SEED;
        else if (restart_i) state_q <= SEED;
        else if (step_i)    state_q <= next_val;
    end

    assign state_o = state_q;

    // R3: the register never reaches the all-zero lock-up state
    a_r3_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != '0);

    // R3: without a step or restart the register holds
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !restart_i) |=> $stable(state_o));

    // R7: a restart reloads the seed
    a_r7_seed_reload: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (state_o == SEED));

endmodule

// File: rtl/dws_tri_counter.sv
`timescale 1ns/1ps
module dws_tri_counter #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              step_i,
    input  logic              up_i,
    input  logic [DATA_W-1:0] peak_i,
    output logic [DATA_W-1:0] count_o,
    output logic              at_peak_o,
    output logic              at_floor_o
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         count_q <= '0;
        else if (restart_i) count_q <= '0;
        else if (step_i)    count_q <= up_i ? (count_q + ONE) : (count_q - ONE);
    end

    assign count_o    = count_q;
    assign at_peak_o  = (count_q >= peak_i);
    assign at_floor_o = (count_q == '0);

    // R5: a rising step adds exactly one
    a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && up_i && !restart_i) |=> (count_o == $past(count_o) + ONE));

    // R5: the controller never asks for a step below zero
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !up_i) |-> (count_o != '0));

    // R5: the controller never asks to climb past the peak
    a_r5_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && up_i) |-> (count_o < peak_i));

    // R7: a restart clears the count
    a_r7_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (count_o == '0));

endmodule

// File: rtl/dws_mode_fsm.sv
`timescale 1ns/1ps
module dws_mode_fsm
    import dws_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  mode_i,
    input  logic        trig_i,
    input  logic        at_peak_i,
    input  logic        at_floor_i,
    output wave_state_e state_o,
    output logic        restart_o,
    output logic        noise_step_o,
    output logic        tri_step_o,
    output logic        tri_up_o
);

    wave_state_e state_q, state_d;
    logic [1:0]  mode_q;
    logic        mode_change;

    assign mode_change = (mode_i != mode_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PASS;
            mode_q  <= 2'b00;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_i;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (mode_change) begin
            state_d = entry_state(mode_i);
        end else begin
            unique case (state_q)
                ST_PASS:  state_d = ST_PASS;
                ST_NOISE: state_d = ST_NOISE;
                ST_RISE:  if (trig_i && at_peak_i)  state_d = ST_FALL;
                ST_FALL:  if (trig_i && at_floor_i) state_d = ST_RISE;
            endcase
        end
    end

    // Output logic
    always_comb begin
        restart_o    = mode_change;
        noise_step_o = 1'b0;
        tri_step_o   = 1'b0;
        tri_up_o     = 1'b1;
        unique case (state_q)
            ST_PASS: begin
                tri_up_o = 1'b1;
            end
            ST_NOISE: begin
                noise_step_o = trig_i && !mode_change;
            end
            ST_RISE: begin
                tri_step_o = trig_i && !mode_change;
                tri_up_o   = !at_peak_i;
            end
            ST_FALL: begin
                tri_step_o = trig_i && !mode_change;
                tri_up_o   = at_floor_i;
            end
        endcase
    end

    assign state_o = state_q;

    // R7: a mode change lands in the entry state for the new code
    a_r7_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != mode_q) |=> (state_o == entry_state($past(mode_i))));

    // R5: a trigger at the peak while rising turns the wave down
    a_r5_turn_down: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RISE && trig_i && at_peak_i && !mode_change) |=> (state_o == ST_FALL));

    // R10: without a trigger or mode change the state holds
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_i && !mode_change) |=> $stable(state_o));

endmodule

// File: rtl/dac_wave_shaper.sv
`timescale 1ns/1ps
module dac_wave_shaper
    import dws_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int AMP_W  = 4,
    parameter logic [DATA_W-1:0] SEED = 12'hAAA,
    parameter logic [DATA_W-1:0] TAPS = 12'h053
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [AMP_W-1:0]  amp_i,
    input  logic [DATA_W-1:0] base_i,
    input  logic              trig_i,
    output logic [DATA_W-1:0] result_o
);

    wave_state_e       state;
    logic              restart, noise_step, tri_step, tri_up;
    logic              at_peak, at_floor;
    logic [DATA_W-1:0] span_mask;
    logic [DATA_W-1:0] noise_val;
    logic [DATA_W-1:0] tri_val;
    logic [DATA_W-1:0] addend;

    dws_span_mask #(.DATA_W(DATA_W), .AMP_W(AMP_W)) mask_i (
        .amp_i  (amp_i),
        .mask_o (span_mask)
    );

    dws_mode_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode_i),
        .trig_i       (trig_i),
        .at_peak_i    (at_peak),
        .at_floor_i   (at_floor),
        .state_o      (state),
        .restart_o    (restart),
        .noise_step_o (noise_step),
        .tri_step_o   (tri_step),
        .tri_up_o     (tri_up)
    );

    dws_lfsr #(.DATA_W(DATA_W), .SEED(SEED), .TAPS(TAPS)) lfsr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .step_i    (noise_step),
        .state_o   (noise_val)
    );

    dws_tri_counter #(.DATA_W(DATA_W)) tri_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (restart),
        .step_i     (tri_step),
        .up_i       (tri_up),
        .peak_i     (span_mask),
        .count_o    (tri_val),
        .at_peak_o  (at_peak),
        .at_floor_o (at_floor)
    );

    // Waveform offset selection
    always_comb begin
        unique case (state)
            ST_PASS:  addend = '0;
            ST_NOISE: addend = noise_val & span_mask;
            ST_RISE,
            ST_FALL:  addend = tri_val;
        endcase
    end

    // Modulo-2^DATA_W sum
    assign result_o = base_i + addend;

    // R1: pass-through state outputs the base word
    a_r1_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS) |-> (result_o == base_i));

    // R4: the noise offset has no bits above the span
    a_r4_noise_span: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NOISE) |-> (((result_o - base_i) & ~span_mask) == '0));

endmodule

// File: tb/dac_wave_shaper_tb.sv
`timescale 1ns/1ps
module dac_wave_shaper_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [3:0]  amp = 4'd0;
    logic [11:0] base = 12'h000;
    logic        trig = 1'b0;
    logic [11:0] result;

    int vectors = 0;
    int fails   = 0;

    // Reference model state
    logic [11:0] r_lf  = 12'hAAA;
    logic [11:0] r_cnt = 12'h000;
    logic        r_up  = 1'b1;
    logic [1:0]  r_mq  = 2'b00;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_wave_shaper dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode),
        .amp_i    (amp),
        .base_i   (base),
        .trig_i   (trig),
        .result_o (result)
    );

    // R4: min(N+1,12) low ones
    function automatic logic [11:0] fmask(input logic [3:0] a);
        logic [11:0] m;
        for (int i = 0; i < 12; i++) m[i] = (i <= int'(a));
        return m;
    endfunction

    // R3: fb = s0^s1^s4^s6, next = {fb, s[11:1]}, zero replaced by 0xAAA
    function automatic logic [11:0] lfsr_next(input logic [11:0] s);
        logic [11:0] n;
        n = {s[0] ^ s[1] ^ s[4] ^ s[6], s[11:1]};
        if (n == 12'h000) n = 12'hAAA;
        return n;
    endfunction

    function automatic logic [11:0] expected();
        if (r_mq == 2'b00)      return base;
        else if (r_mq == 2'b01) return base + (r_lf & fmask(amp));
        else                    return base + r_cnt;
    endfunction

    task automatic check(input string tag);
        logic [11:0] e;
        e = expected();
        vectors++;
        if (result !== e) begin
            fails++;
            $display("FAIL %s: mode=%b amp=%0d base=%h result=%h expected=%h",
                     tag, mode, amp, base, result, e);
        end
    endtask

    // Drive at negedge, update model at posedge, compare a quarter period later
    task automatic apply(input logic [1:0] m, input logic [3:0] a,
                         input logic [11:0] b, input logic t, input string tag);
        string tg;
        @(negedge clk);
        mode = m; amp = a; base = b; trig = t;
        @(posedge clk);
        if (m != r_mq) begin
            r_mq = m; r_lf = 12'hAAA; r_cnt = 12'h000; r_up = 1'b1;
        end else if (t) begin
            if (m == 2'b01) begin
                r_lf = lfsr_next(r_lf);
            end else if (m[1]) begin
                if (r_up) begin
                    if (r_cnt >= fmask(a)) begin r_up = 1'b0; r_cnt = r_cnt - 12'd1; end
                    else r_cnt = r_cnt + 12'd1;
                end else begin
                    if (r_cnt == 12'h000) begin r_up = 1'b1; r_cnt = 12'd1; end
                    else r_cnt = r_cnt - 12'd1;
                end
            end
        end
        #(CLK_PERIOD/4);
        if (tag != "") tg = tag;
        else if (m == 2'b00) tg = "R1";
        else if (m == 2'b01) tg = t ? "R3" : "R2";
        else tg = "R5";
        check(tg);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : main
        // R9: reset state is pass-through even with a noise code applied
        mode = 2'b01; base = 12'h5A5; amp = 4'd11;
        repeat (3) @(posedge clk);
        @(negedge clk);
        vectors++;
        if (result !== 12'h5A5) begin
            fails++;
            $display("FAIL R9: result=%h expected=%h", result, 12'h5A5);
        end
        mode = 2'b00;
        rst_n = 1'b1;
        apply(2'b00, 4'd3, 12'h5A5, 1'b0, "R9");

        // R1: pass-through sweep, triggers and amplitude have no effect
        for (int i = 0; i < 4096; i += 17)
            apply(2'b00, 4'(i), 12'(i), 1'(i % 2), "R1");

        // R2/R3/R4: noise for every amplitude code
        for (int a = 0; a < 16; a++) begin
            apply(2'b00, 4'(a), 12'h000, 1'b0, "R1");
            apply(2'b01, 4'(a), 12'(a * 251), 1'b0, "R7");
            for (int i = 0; i < 200; i++)
                apply(2'b01, 4'(a), 12'((i * 37 + a * 411) % 4096), 1'((i % 3) != 0),
                      (a < 11) ? "R4" : "");
        end

        // R5: triangle over a full period for every amplitude code, alternating 10 and 11
        for (int a = 0; a < 16; a++) begin
            int k;
            k = (a + 1 < 12) ? a + 1 : 12;
            apply((a % 2) ? 2'b11 : 2'b10, 4'(a), 12'h100, 1'b0, "R7");
            for (int i = 0; i < 2 * (1 << k) + 3; i++)
                apply((a % 2) ? 2'b11 : 2'b10, 4'(a), 12'((i * 13) % 4096), 1'b1, "R5");
        end

        // R6: lower amplitude while climbing above the new peak
        apply(2'b00, 4'd11, 12'h000, 1'b0, "R1");
        for (int i = 0; i < 100; i++) apply(2'b10, 4'd11, 12'h020, 1'b1, "R5");
        for (int i = 0; i < 140; i++) apply(2'b10, 4'd3, 12'h020, 1'b1, "R6");

        // R7: mode change with a trigger in the same cycle
        for (int i = 0; i < 5; i++) apply(2'b01, 4'd11, 12'h010, 1'b1, "R3");
        apply(2'b10, 4'd11, 12'h010, 1'b1, "R7");
        for (int i = 0; i < 7; i++) apply(2'b10, 4'd11, 12'h010, 1'b1, "R5");
        apply(2'b11, 4'd11, 12'h010, 1'b1, "R7");
        apply(2'b11, 4'd11, 12'h010, 1'b1, "R7");
        apply(2'b01, 4'd11, 12'h010, 1'b1, "R7");

        // R8: wrap near full scale
        for (int i = 0; i < 40; i++) apply(2'b01, 4'd11, 12'hFFF - 12'(i), 1'b1, "R8");
        apply(2'b10, 4'd3, 12'hFF8, 1'b0, "R8");
        for (int i = 0; i < 40; i++) apply(2'b10, 4'd3, 12'hFF8, 1'b1, "R8");

        // R10: no trigger, state holds while base and amplitude follow at once
        for (int i = 0; i < 30; i++) apply(2'b10, 4'(i % 16), 12'(i * 131), 1'b0, "R10");
        for (int i = 0; i < 30; i++) apply(2'b01, 4'(i % 16), 12'(i * 97), 1'b0, "R10");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule